// File: doc/BRIEF.md
# I2C Control Register Slave

This block lets an I2C host read and write two 8-bit control registers. It samples the SCL and SDA pins with the system clock. Each line passes through a two-flop synchronizer and then a glitch filter. The filtered lines are used to find START, repeated START and STOP, and to shift bytes in and out. SDA is driven as an open-drain output: `sda_oe` high pulls the line low, and low releases it.

A write carries the slave address with R/W=0, a register pointer byte and one data byte. A read first writes the pointer. The host then issues a repeated START, sends the address with R/W=1 and clocks data out, MSB first. Register 0 is a plain control register. Register 1 holds three writable enable bits, and its top bit returns the live `load_i` input.

Each time register 1 is loaded for transmission, the block emits a one-cycle strobe, `stat_rd_o`. Neighbouring flag logic uses this strobe to clear on read.

Top module: `i2c_ctrl_slave`

## Requirements
- R1: A START followed by an address byte whose upper seven bits equal `SLV_ADDR` is acknowledged. The acknowledge is SDA pulled low during the ninth clock. On a different address the block gives no acknowledge and ignores all bytes until the next START.
- R2: In a write, the address byte (R/W bit 0) is followed by a pointer byte and then a data byte. Each of these bytes is acknowledged. The data byte is stored in the register the pointer selects. Register contents change only when such a data byte completes.
- R3: A pointer byte above 0x01 is not acknowledged, and the data byte after it changes no register.
- R4: Only one data byte is accepted per write. Any further byte before STOP is not acknowledged and is discarded.
- R5: In register 0, bits 7, 6, 4, 3, 1 and 0 are writable and are driven on `cfg_o`. Bits 5 and 2 read as 0 and ignore writes.
- R6: In register 1, bits 3, 1 and 0 are writable and are driven on `det_o`. Bit 7 reads back `load_i` as sampled when the byte is loaded, and writes to it are ignored. Bits 6, 5, 4 and 2 read as 0.
- R7: A read consists of a pointer write, a repeated START, and the address with R/W bit 1. The selected register is then returned MSB first. Each bit is placed on SDA after an SCL falling edge.
- R8: The pointer advances after each byte loaded for reading, wrapping from 1 to 0. The next byte is sent while the host acknowledges. A host not-acknowledge ends the read, and SDA stays released.
- R9: `stat_rd_o` pulses for exactly one clock each time register 1 is loaded for transmission. It never pulses for register 0.
- R10: A START or STOP inside a byte aborts the transfer without changing any register. After a STOP, SDA is released. After a START, the block expects a new address byte.
- R11: A pulse on SCL or SDA that lasts fewer than `FILT_CYC` clocks after synchronization is ignored.
- R12: After reset both registers are 0x00 and SDA is released. SDA is never pulled low while the block is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock pin level |
| sda_i | input | 1 | Serial data pin level |
| sda_oe | output | 1 | High pulls SDA low; low releases it |
| load_i | input | 1 | Load status, returned in register 1 bit 7 |
| cfg_o | output | 8 | Register 0 contents |
| det_o | output | 8 | Register 1 writable bits (bit 7 always 0) |
| stat_rd_o | output | 1 | One-cycle strobe when register 1 is loaded for a read |

## Verification
A wrong sequencer state shows within one byte. It appears either as a missing or extra acknowledge in the ninth clock, or as SDA held low where the host expects a released line. A bad bit count or a bad pointer shows as a readback byte that differs from the masked value written, or as a wrong order in a three-byte read. A wrong register mask or a stray write appears on `cfg_o` or `det_o` as soon as the transaction ends. A wrong strobe decision shows as a count of `stat_rd_o` pulses that differs from the number of register 1 bytes sent.

// File: rtl/i2c_ctrl_slave.sv
module i2c_ctrl_slave #(
  parameter logic [6:0] SLV_ADDR = 7'h3C,
  parameter int         FILT_CYC = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       load_i,
  output logic [7:0] cfg_o,
  output logic [7:0] det_o,
  output logic       stat_rd_o
);
  localparam int         CW       = $clog2(FILT_CYC + 1);
  localparam logic [7:0] CFG_MASK = 8'hDB;
  localparam logic [7:0] DET_MASK = 8'h0B;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_AACK, S_PTR, S_PACK, S_WDAT, S_WACK, S_RDAT, S_RACK
  } st_t;

  logic [1:0] pin_in, line_f, line_d;
  assign pin_in = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;
    logic          filt_q, dly_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync_q <= 2'b11;
        cnt_q  <= '0;
        filt_q <= 1'b1;
        dly_q  <= 1'b1;
      end else begin
        sync_q <= {sync_q[0], pin_in[g]};
        dly_q  <= filt_q;
        if (sync_q[1] == filt_q) cnt_q <= '0;
        else if (cnt_q == CW'(FILT_CYC - 1)) begin
          filt_q <= sync_q[1];
          cnt_q  <= '0;
        end else cnt_q <= cnt_q + 1'b1;
      end
    end
    assign line_f[g] = filt_q;
    assign line_d[g] = dly_q;
  end

  logic scl_f, sda_f, scl_d, sda_d;
  assign {scl_f, sda_f} = line_f;
  assign {scl_d, sda_d} = line_d;

  logic scl_rise, scl_fall, start_det, stop_det;
  assign scl_rise  = scl_f & ~scl_d;
  assign scl_fall  = ~scl_f & scl_d;
  assign start_det = scl_f & scl_d & sda_d & ~sda_f;
  assign stop_det  = scl_f & scl_d & ~sda_d & sda_f;

  st_t        state_q;
  logic [3:0] bit_q;
  logic [7:0] sh_q, tx_q, rd_val;
  logic       ptr_q, rw_q, mack_q;

  assign rd_val = ptr_q ? {load_i, det_o[6:0]} : cfg_o;

  logic byte_done;
  assign byte_done = scl_fall && (bit_q == 4'd8);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      bit_q     <= '0;
      sh_q      <= '0;
      tx_q      <= '0;
      ptr_q     <= 1'b0;
      rw_q      <= 1'b0;
      mack_q    <= 1'b0;
      sda_oe    <= 1'b0;
      cfg_o     <= '0;
      det_o     <= '0;
      stat_rd_o <= 1'b0;
    end else begin
      stat_rd_o <= 1'b0;
      if (start_det) begin
        state_q <= S_ADDR;
        bit_q   <= '0;
        sda_oe  <= 1'b0;
      end else if (stop_det) begin
        state_q <= S_IDLE;
        sda_oe  <= 1'b0;
      end else begin
        case (state_q)
          S_ADDR, S_PTR, S_WDAT: begin
            if (scl_rise) begin
              sh_q  <= {sh_q[6:0], sda_f};
              bit_q <= bit_q + 1'b1;
            end else if (byte_done) begin
              if (state_q == S_ADDR) begin
                if (sh_q[7:1] == SLV_ADDR) begin
                  rw_q    <= sh_q[0];
                  sda_oe  <= 1'b1;
                  state_q <= S_AACK;
                end else state_q <= S_IDLE;
              end else if (state_q == S_PTR) begin
                if (sh_q[7:1] == 7'd0) begin
                  ptr_q   <= sh_q[0];
                  sda_oe  <= 1'b1;
                  state_q <= S_PACK;
                end else state_q <= S_IDLE;
              end else begin
                if (ptr_q) det_o <= sh_q & DET_MASK;
                else       cfg_o <= sh_q & CFG_MASK;
                sda_oe  <= 1'b1;
                state_q <= S_WACK;
              end
            end
          end
          S_AACK: if (scl_fall) begin
            bit_q <= '0;
            if (rw_q) begin
              tx_q      <= rd_val;
              sda_oe    <= ~rd_val[7];
              stat_rd_o <= ptr_q;
              ptr_q     <= ~ptr_q;
              state_q   <= S_RDAT;
            end else begin
              sda_oe  <= 1'b0;
              state_q <= S_PTR;
            end
          end
          S_PACK: if (scl_fall) begin
            sda_oe  <= 1'b0;
            bit_q   <= '0;
            state_q <= S_WDAT;
          end
          S_WACK: if (scl_fall) begin
            sda_oe  <= 1'b0;
            state_q <= S_IDLE;
          end
          S_RDAT: if (scl_fall) begin
            if (bit_q == 4'd7) begin
              sda_oe  <= 1'b0;
              state_q <= S_RACK;
            end else begin
              tx_q   <= tx_q << 1;
              sda_oe <= ~tx_q[6];
              bit_q  <= bit_q + 1'b1;
            end
          end
          S_RACK: begin
            if (scl_rise) mack_q <= ~sda_f;
            else if (scl_fall) begin
              if (mack_q) begin
                tx_q      <= rd_val;
                sda_oe    <= ~rd_val[7];
                stat_rd_o <= ptr_q;
                ptr_q     <= ~ptr_q;
                bit_q     <= '0;
                state_q   <= S_RDAT;
              end else state_q <= S_IDLE;
            end
          end
          default: sda_oe <= 1'b0;
        endcase
      end
    end
  end
endmodule

module i2c_ctrl_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_oe,
  input logic       stat_rd_o,
  input logic       stop_seen,
  input logic [3:0] state,
  input logic [7:0] cfg_o,
  input logic [7:0] det_o
);
  localparam logic [3:0] ST_IDLE = 4'd0;
  localparam logic [3:0] ST_WDAT = 4'd5;

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd_o |=> !stat_rd_o); // R9
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe); // R12
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen |=> (!sda_oe && state == ST_IDLE)); // R10
  AST_CFG_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_o & 8'h24) == 8'h00); // R5
  AST_DET_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (det_o & 8'hF4) == 8'h00); // R6
  AST_WRITE_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({cfg_o, det_o}) |-> ($past(state) == ST_WDAT)); // R2
endmodule

bind i2c_ctrl_slave i2c_ctrl_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .stat_rd_o(stat_rd_o),
  .stop_seen(stop_det), .state(state_q), .cfg_o(cfg_o), .det_o(det_o)
);

// File: tb/i2c_ctrl_slave_tb.sv
module i2c_ctrl_slave_tb;
  localparam logic [6:0] ADDR = 7'h3C;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, load_i = 1'b0;
  logic sda_oe, stat_rd_o, sda_line;
  logic [7:0] cfg_o, det_o;
  int n_chk = 0, n_fail = 0, strb = 0;

  always #2 clk = ~clk;
  assign sda_line = m_sda & ~sda_oe;

  i2c_ctrl_slave #(.SLV_ADDR(ADDR), .FILT_CYC(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .load_i(load_i), .cfg_o(cfg_o), .det_o(det_o), .stat_rd_o(stat_rd_o));

  always @(posedge clk) if (stat_rd_o) strb <= strb + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic w(input int n); repeat (n) @(negedge clk); endtask

  task automatic bus_bit(input logic b, output logic r);
    m_sda = b; w(Q); m_scl = 1'b1; w(Q); r = sda_line; w(Q); m_scl = 1'b0; w(Q);
  endtask

  task automatic bus_start;
    m_sda = 1'b1; w(Q); m_scl = 1'b1; w(Q); m_sda = 1'b0; w(Q); m_scl = 1'b0; w(Q);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; w(Q); m_scl = 1'b1; w(Q); m_sda = 1'b1; w(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input int glitch_at, output logic ack);
    logic r;
    for (int k = 7; k >= 0; k--) begin
      if (k == glitch_at) begin
        m_sda = b[k]; w(Q); m_scl = 1'b1; w(2); m_scl = 1'b0; w(Q);
      end
      bus_bit(b[k], r);
    end
    bus_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic recv_byte(input logic more, output logic [7:0] b);
    logic r;
    for (int k = 7; k >= 0; k--) begin
      bus_bit(1'b1, r);
      b[k] = r;
    end
    bus_bit(~more, r);
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] p, input logic [7:0] d,
                          input int glitch_at, output logic [2:0] acks);
    bus_start;
    send_byte({a, 1'b0}, -1, acks[2]);
    send_byte(p, -1, acks[1]);
    send_byte(d, glitch_at, acks[0]);
    bus_stop;
  endtask

  task automatic do_read(input logic [7:0] p, input int n, output logic [23:0] data,
                         output logic [2:0] acks);
    logic [7:0] b;
    data = '0;
    bus_start;
    send_byte({ADDR, 1'b0}, -1, acks[2]);
    send_byte(p, -1, acks[1]);
    bus_start;
    send_byte({ADDR, 1'b1}, -1, acks[0]);
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, b);
      data = {data[15:0], b};
    end
    bus_stop;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [2:0] acks;
    logic [23:0] rd;
    logic a;
    int s0;
    w(5);
    chk("R12 reset cfg", cfg_o, 0);
    chk("R12 reset det", det_o, 0);
    chk("R12 reset sda", sda_oe, 0);
    rst_n = 1'b1;
    w(20);

    for (int i = 0; i < 16; i++) begin
      logic [7:0] v = 8'(i * 37 + 5);
      do_write(ADDR, 8'h00, v, -1, acks);
      chk("R2 write acks", acks, 3'b111);
      chk("R5 cfg value", cfg_o, v & 8'hDB);
      s0 = strb;
      do_read(8'h00, 1, rd, acks);
      chk("R7 read reg0", rd[7:0], v & 8'hDB);
      chk("R9 no strobe reg0", strb - s0, 0);
      chk("R12 released after read", sda_oe, 0);
    end

    for (int i = 0; i < 16; i++) begin
      logic [7:0] v = 8'(i * 53 + 11);
      load_i = i[0];
      do_write(ADDR, 8'h01, v, -1, acks);
      chk("R2 write acks reg1", acks, 3'b111);
      chk("R6 det value", det_o, v & 8'h0B);
      s0 = strb;
      do_read(8'h01, 1, rd, acks);
      chk("R6 read reg1", rd[7:0], {i[0], 7'd0} | (v & 8'h0B));
      chk("R9 strobe count", strb - s0, 1);
    end

    do_write(ADDR, 8'h00, 8'hC3, -1, acks);
    do_write(ADDR, 8'h01, 8'h09, -1, acks);
    load_i = 1'b1;
    do_write(ADDR ^ 7'h01, 8'h00, 8'h00, -1, acks);
    chk("R1 wrong address no ack", acks, 3'b000);
    chk("R1 wrong address no write", cfg_o, 8'hC3);
    do_write(ADDR, 8'h02, 8'h00, -1, acks);
    chk("R3 bad pointer acks", acks, 3'b100);
    chk("R3 bad pointer no write", {cfg_o, det_o}, {8'hC3, 8'h09});
    do_write(ADDR, 8'h81, 8'h00, -1, acks);
    chk("R3 high pointer acks", acks, 3'b100);
    chk("R3 high pointer no write", det_o, 8'h09);

    bus_start;
    send_byte({ADDR, 1'b0}, -1, a);
    send_byte(8'h00, -1, a);
    send_byte(8'h5A, -1, a);
    chk("R4 first data ack", a, 1);
    send_byte(8'hFF, -1, a);
    chk("R4 extra byte nack", a, 0);
    bus_stop;
    chk("R4 only first byte stored", cfg_o, 8'h5A & 8'hDB);
    do_write(ADDR, 8'h00, 8'hC3, -1, acks);

    s0 = strb;
    do_read(8'h01, 3, rd, acks);
    chk("R8 three byte wrap", rd, {8'h89, 8'hC3, 8'h89});
    chk("R8 strobes", strb - s0, 2);
    chk("R8 released after nack", sda_oe, 0);

    bus_start;
    send_byte({ADDR, 1'b0}, -1, a);
    send_byte(8'h00, -1, a);
    for (int k = 0; k < 4; k++) bus_bit(1'b0, a);
    bus_stop;
    chk("R10 stop mid byte", cfg_o, 8'hC3);
    chk("R10 released after stop", sda_oe, 0);
    bus_start;
    send_byte({ADDR, 1'b0}, -1, a);
    send_byte(8'h01, -1, a);
    for (int k = 0; k < 3; k++) bus_bit(1'b0, a);
    bus_start;
    send_byte({ADDR, 1'b0}, -1, a);
    chk("R10 start mid byte re-addresses", a, 1);
    bus_stop;
    chk("R10 start mid byte no write", det_o, 8'h09);

    do_write(ADDR, 8'h00, 8'h99, 3, acks);
    chk("R11 scl glitch acks", acks, 3'b111);
    chk("R11 scl glitch ignored", cfg_o, 8'h99 & 8'hDB);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule